// File: doc/BRIEF.md
# Three-Port Register File

This block is the general-purpose register file of a small 8-bit RISC datapath. It holds eight 8-bit words. One write port stores a word on the rising clock edge. Two read ports, A and B, each read any word at any time, independently of each other. Each port decodes its own 3-bit address through a 3-to-8 one-hot decoder with an enable. For the write port, the enable is the write strobe.

The read ports are shared buses. The selected word drives its port's bus through an inverting tri-state stage, so each bus carries the bitwise complement of the stored word. When a port's enable is low, no word is selected and that bus floats. A drive-enable output per port tells the surrounding datapath whether the bus is being driven. Reads are combinational, so a word being written shows its old contents until the capturing edge.

Top module: `tri_port_regfile`

## Requirements
- R1: A synchronous active-high reset clears all eight words to zero, so an enabled read port then shows 8'hFF.
- R2: When the write enable is high at a rising clock edge, the word selected by the write address loads the write data.
- R3: When the write enable is low at a rising clock edge, no word changes.
- R4: A write changes only the addressed word; the other seven words keep their values.
- R5: While a read port is enabled, its bus shows the bitwise complement of the word at that port's address, with no clock edge needed.
- R6: While a read port's enable is low, its drive-enable output is 0 and all 8 bits of its bus are high-impedance. While the enable is high, the drive-enable output is 1.
- R7: Ports A and B may address the same word at the same time, and both buses then show its complement.
- R8: A read of the word being written in the same cycle shows the old contents before the clock edge and the new contents after it.
- R9: Each port's decoder selects at most one word, so no bus is ever driven by two words at once.
- R10: Ports A and B read different addresses independently of each other in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all words |
| wr_en | input | 1 | Write strobe, also the enable of the write decoder |
| wr_addr | input | 3 | Index of the word to write |
| wr_data | input | 8 | Data to store |
| rd_a_en | input | 1 | Port A decoder enable |
| rd_a_addr | input | 3 | Port A word index |
| rd_a_bus | output | 8 | Port A bus, complement of the selected word, or floating |
| rd_a_drv | output | 1 | High while port A drives its bus |
| rd_b_en | input | 1 | Port B decoder enable |
| rd_b_addr | input | 3 | Port B word index |
| rd_b_bus | output | 8 | Port B bus, complement of the selected word, or floating |
| rd_b_drv | output | 1 | High while port B drives its bus |

## Verification
The bench writes a distinct pattern to every word and reads each one back on both ports. A missing inversion or a mis-decoded address shows up as the wrong value on a bus. It drops the write strobe while new data sits on the write port, so a decoder that ignored its enable would corrupt a word. It also disables each read port in turn. A port that kept driving would still report its drive-enable high. Finally, it reads a word in the same cycle it is written: a read path that went through a register would show the new data too early or the old data too late.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

    // Default geometry of the register file.
    localparam int RF_ADDR_W = 3;
    localparam int RF_DATA_W = 8;
    localparam int RF_DEPTH  = 1 << RF_ADDR_W;

endpackage

// File: rtl/rf_decoder.sv
// One-hot address decoder with an enable; all outputs stay low when disabled.
module rf_decoder #(
    parameter int ADDR_W = regfile_pkg::RF_ADDR_W,
    localparam int OUTS  = 1 << ADDR_W
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic [OUTS-1:0]   sel
);

    for (genvar i = 0; i < OUTS; i++) begin : g_line
        assign sel[i] = en && (addr == ADDR_W'(i));
    end

endmodule

// File: rtl/rf_word_store.sv
// Flip-flop storage: one register word per entry, loaded by a one-hot strobe.
module rf_word_store #(
    parameter int DATA_W = regfile_pkg::RF_DATA_W,
    parameter int DEPTH  = regfile_pkg::RF_DEPTH
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [DEPTH-1:0]             load,
    input  logic [DATA_W-1:0]            din,
    output logic [DEPTH-1:0][DATA_W-1:0] words
);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] word;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (load[i]) begin
                st_d.word[i] = din;
            end
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign words = st_q.word;

endmodule

// File: rtl/rf_read_port.sv
// Read port: one-hot select of a word, inverted, onto a tri-state bus.
module rf_read_port #(
    parameter int DATA_W = regfile_pkg::RF_DATA_W,
    parameter int DEPTH  = regfile_pkg::RF_DEPTH
) (
    input  logic [DEPTH-1:0]             sel,
    input  logic [DEPTH-1:0][DATA_W-1:0] words,
    output logic [DATA_W-1:0]            bus,
    output logic                         drv
);

    logic [DATA_W-1:0] picked;

    // The select is one-hot, so OR-ing the gated words yields the chosen word.
    always_comb begin
        picked = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sel[i]) begin
                picked = picked | words[i];
            end
        end
    end

    assign drv = |sel;
    assign bus = drv ? ~picked : {DATA_W{1'bz}};

endmodule

// File: rtl/tri_port_regfile.sv
// Eight-word register file with one write port and two inverting read buses.
module tri_port_regfile #(
    parameter int ADDR_W = regfile_pkg::RF_ADDR_W,
    parameter int DATA_W = regfile_pkg::RF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_a_en,
    input  logic [ADDR_W-1:0] rd_a_addr,
    output logic [DATA_W-1:0] rd_a_bus,
    output logic              rd_a_drv,
    input  logic              rd_b_en,
    input  logic [ADDR_W-1:0] rd_b_addr,
    output logic [DATA_W-1:0] rd_b_bus,
    output logic              rd_b_drv
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DEPTH-1:0]             sel_w;
    logic [DEPTH-1:0]             sel_a;
    logic [DEPTH-1:0]             sel_b;
    logic [DEPTH-1:0][DATA_W-1:0] words;

    rf_decoder #(.ADDR_W(ADDR_W)) u_dec_w (.en(wr_en),   .addr(wr_addr),   .sel(sel_w));
    rf_decoder #(.ADDR_W(ADDR_W)) u_dec_a (.en(rd_a_en), .addr(rd_a_addr), .sel(sel_a));
    rf_decoder #(.ADDR_W(ADDR_W)) u_dec_b (.en(rd_b_en), .addr(rd_b_addr), .sel(sel_b));

    rf_word_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .load  (sel_w),
        .din   (wr_data),
        .words (words)
    );

    rf_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_port_a (
        .sel   (sel_a),
        .words (words),
        .bus   (rd_a_bus),
        .drv   (rd_a_drv)
    );

    rf_read_port #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_port_b (
        .sel   (sel_b),
        .words (words),
        .bus   (rd_b_bus),
        .drv   (rd_b_drv)
    );

endmodule

// File: rtl/rf_checker.sv
// Property checker for tri_port_regfile, attached through bind below.
module rf_checker #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [DATA_W-1:0]            wr_data,
    input logic                         rd_a_en,
    input logic [ADDR_W-1:0]            rd_a_addr,
    input logic [DATA_W-1:0]            rd_a_bus,
    input logic                         rd_a_drv,
    input logic                         rd_b_en,
    input logic [ADDR_W-1:0]            rd_b_addr,
    input logic [DATA_W-1:0]            rd_b_bus,
    input logic                         rd_b_drv,
    input logic [DEPTH-1:0]             sel_a,
    input logic [DEPTH-1:0]             sel_b,
    input logic [DEPTH-1:0][DATA_W-1:0] words
);

    logic rst_seen;
    initial rst_seen = 1'b0;
    always @(posedge clk) rst_seen <= rst;

    // R1: the cycle after a reset edge every word is zero.
    always @(negedge clk) begin
        if (rst_seen) begin
            p_reset_clear_r1: assert (words == '0);
        end
    end

    p_write_loads_r2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> words[$past(wr_addr)] == $past(wr_data));

    p_no_write_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(words));

    p_read_a_inv_r5: assert property (@(posedge clk) disable iff (rst)
        rd_a_en |-> rd_a_bus == ~words[rd_a_addr]);

    p_read_b_inv_r5: assert property (@(posedge clk) disable iff (rst)
        rd_b_en |-> rd_b_bus == ~words[rd_b_addr]);

    p_float_a_r6: assert property (@(posedge clk) disable iff (rst)
        rd_a_drv == rd_a_en);

    p_float_b_r6: assert property (@(posedge clk) disable iff (rst)
        rd_b_drv == rd_b_en);

    p_single_driver_a_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_a));

    p_single_driver_b_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_b));

endmodule

bind tri_port_regfile rf_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_a_en   (rd_a_en),
    .rd_a_addr (rd_a_addr),
    .rd_a_bus  (rd_a_bus),
    .rd_a_drv  (rd_a_drv),
    .rd_b_en   (rd_b_en),
    .rd_b_addr (rd_b_addr),
    .rd_b_bus  (rd_b_bus),
    .rd_b_drv  (rd_b_drv),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .words     (words)
);

// File: tb/tb_tri_port_regfile.sv
module tb_tri_port_regfile;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_a_en = 1'b0;
    logic [2:0] rd_a_addr = '0;
    logic [7:0] rd_a_bus;
    logic       rd_a_drv;
    logic       rd_b_en = 1'b0;
    logic [2:0] rd_b_addr = '0;
    logic [7:0] rd_b_bus;
    logic       rd_b_drv;

    int tests = 0;
    int fails = 0;
    logic [7:0] model [8];

    always #10 clk = ~clk;

    tri_port_regfile dut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_a_en(rd_a_en), .rd_a_addr(rd_a_addr), .rd_a_bus(rd_a_bus), .rd_a_drv(rd_a_drv),
        .rd_b_en(rd_b_en), .rd_b_addr(rd_b_addr), .rd_b_bus(rd_b_bus), .rd_b_drv(rd_b_drv)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Store d at word a; inputs change at the falling edge, capture at the next rising edge.
    task automatic write_word(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        model[a] = d;
    endtask

    task automatic read_both(input string req, input logic [2:0] a, input logic [2:0] b);
        rd_a_en = 1'b1; rd_a_addr = a;
        rd_b_en = 1'b1; rd_b_addr = b;
        #1;
        check({req, " port A"}, rd_a_bus, ~model[a]);
        check({req, " port B"}, rd_b_bus, ~model[b]);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        for (int i = 0; i < 8; i++) read_both("R1 reset reads FF", 3'(i), 3'(i));
    endtask

    task automatic t_write_all;
        for (int i = 0; i < 8; i++) write_word(3'(i), 8'(8'h11 * i + 8'h05));
        for (int i = 0; i < 8; i++) read_both("R2 R5 write then read", 3'(i), 3'(i));
    endtask

    task automatic t_isolation;
        write_word(3'd3, 8'hC3);
        for (int i = 0; i < 8; i++) read_both("R4 neighbours hold", 3'(i), 3'(7 - i));
    endtask

    task automatic t_write_disabled;
        wr_en = 1'b0; wr_addr = 3'd6; wr_data = 8'h5A;
        @(negedge clk); @(negedge clk);
        read_both("R3 strobe low no change", 3'd6, 3'd6);
    endtask

    task automatic t_float;
        rd_a_en = 1'b0; rd_b_en = 1'b1; rd_b_addr = 3'd2;
        #1;
        check("R6 port A drive off", {7'd0, rd_a_drv}, 8'd0);
        check("R6 port B drive on", {7'd0, rd_b_drv}, 8'd1);
        check("R10 port B alone reads", rd_b_bus, ~model[2]);
        rd_a_en = 1'b1; rd_a_addr = 3'd4; rd_b_en = 1'b0;
        #1;
        check("R6 port B drive off", {7'd0, rd_b_drv}, 8'd0);
        check("R6 port A drive on", {7'd0, rd_a_drv}, 8'd1);
        check("R10 port A alone reads", rd_a_bus, ~model[4]);
        @(negedge clk);
    endtask

    task automatic t_same_word;
        write_word(3'd1, 8'h00);
        read_both("R7 same word both ports", 3'd1, 3'd1);
        write_word(3'd1, 8'hA5);
        read_both("R7 same word both ports", 3'd1, 3'd1);
    endtask

    task automatic t_independent;
        for (int i = 0; i < 8; i++) read_both("R10 distinct addresses", 3'(i), 3'((i + 3) % 8));
    endtask

    task automatic t_read_during_write;
        logic [7:0] old_v;
        old_v = model[5];
        rd_a_en = 1'b1; rd_a_addr = 3'd5;
        rd_b_en = 1'b1; rd_b_addr = 3'd5;
        wr_en = 1'b1; wr_addr = 3'd5; wr_data = 8'h3C;
        #1;
        check("R8 before edge old value", rd_a_bus, ~old_v);
        @(posedge clk); #2;
        check("R8 after edge new value", rd_b_bus, ~8'h3C);
        @(negedge clk);
        wr_en = 1'b0;
        model[5] = 8'h3C;
        check("R8 settled", rd_a_bus, ~8'h3C);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_write_all();
        t_isolation();
        t_write_disabled();
        t_float();
        t_same_word();
        t_independent();
        t_read_during_write();
        t_reset();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule